// File: doc/BRIEF.md
# Checksummed Framing Receiver

This block watches a stream of words that arrive with a valid strobe and a flag marking header words. While idle it looks for a header. The low bits of the header give a payload length. The block then takes that many payload words and writes each one into a packet buffer through a simple write port. The port carries a packet slot, a word slot and the data. While storing, the block keeps a running XOR of the payload. The next word after the payload is the check word. If the check word equals the running XOR, the packet is accepted and the slot counter moves on.

Payload words land at descending word slots, from the length down to 1. A rejected packet leaves the slot counter unchanged, so the next packet overwrites the same buffer slot. Each verdict is reported by a one-cycle accept or reject pulse. The block is meant to sit in front of a packet memory owned by the surrounding logic. That logic reads `pkt_count` to learn how many packets have been committed.

Top module: `frame_xor_rx`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `pkt_count` to 0 and puts the block in its idle phase. Directly after reset, `wr_en`, `pkt_ok` and `pkt_err` are 0.
- R2: While idle, any accepted word with `in_hdr` = 0 is ignored: no write and no pulse occur, and `pkt_count` is unchanged.
- R3: An accepted header word (`in_hdr` = 1 while idle) loads the payload length from `in_word[LEN_W-1:0]`; the other bits of the header are not used. The next N accepted words are written with `wr_idx` = N, N-1, …, 1, with `wr_pkt` equal to the current `pkt_count`. Each write shows `wr_en` = 1 in the cycle after the clock edge that accepted the word.
- R4: Cycles with `in_valid` = 0 change nothing, whatever `in_hdr` and `in_word` hold. This includes a header flag offered without `in_valid`.
- R5: The checksum is the XOR of the payload words only; the header is not included. If the first accepted word after the payload equals the checksum, `pkt_count` increments and `pkt_ok` is 1 for exactly one cycle, in the cycle after that word was accepted.
- R6: If that check word differs from the checksum, `pkt_err` is 1 for one cycle in the same position, and `pkt_count` is unchanged. The next packet therefore writes to the same `wr_pkt` slot. `pkt_ok` and `pkt_err` are never 1 together.
- R7: A header with length 0 goes straight to the check phase. The next accepted word is compared against 0.
- R8: During the payload phase, `in_hdr` is ignored and every accepted word counts as payload. After the check word the block is idle again, whatever the verdict, and a following non-header word is ignored.
- R9: `pkt_count` is PKT_W bits wide and wraps from 2^PKT_W-1 to 0 on an accepted packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is present this cycle |
| in_hdr | input | 1 | Input word is a header |
| in_word | input | DATA_W | Input word; the low LEN_W bits of a header hold the length |
| wr_en | output | 1 | Buffer write strobe |
| wr_pkt | output | PKT_W | Packet slot of the write |
| wr_idx | output | LEN_W | Word slot of the write (length down to 1) |
| wr_data | output | DATA_W | Data of the write |
| pkt_count | output | PKT_W | Accepted packet count, also the current slot |
| pkt_ok | output | 1 | One-cycle pulse: check word matched |
| pkt_err | output | 1 | One-cycle pulse: check word mismatched |

## Verification
The bench sends headers whose upper bits are not zero. A design that folded the header into the XOR, or read the length from the wrong bits, would then report rejects or write the wrong slots. It offers a header flag while the strobe is low, and sets the flag on a payload word. A design that obeyed either would emit writes the scoreboard never expected. A reject followed by a good packet checks that the slot is reused rather than advanced. Zero-length packets check the direct jump to the check phase; a design that waited for a payload word would judge the wrong word. Sixteen accepts in a row expose a counter that saturates instead of wrapping.

// File: rtl/frx_pkg.sv
package frx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BODY = 2'd1,
      ST_TAIL = 2'd2
   } frx_phase_e;
endpackage

// File: rtl/frx_ctrl.sv
module frx_ctrl
   import frx_pkg::*;
#(
   parameter int LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             in_hdr,
   input  logic [LEN_W-1:0] hdr_len,
   output logic             take_hdr,
   output logic             take_body,
   output logic             take_tail,
   output logic [LEN_W-1:0] body_idx
);
   frx_phase_e       phase;
   logic [LEN_W-1:0] remain;

   always_comb begin
      take_hdr  = in_valid && (phase == ST_IDLE) && in_hdr;
      take_body = in_valid && (phase == ST_BODY);
      take_tail = in_valid && (phase == ST_TAIL);
      body_idx  = remain;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase  <= ST_IDLE;
         remain <= '0;
      end else if (take_hdr) begin
         remain <= hdr_len;
         phase  <= (hdr_len == '0) ? ST_TAIL : ST_BODY;
      end else if (take_body) begin
         remain <= remain - 1'b1;
         if (remain == LEN_W'(1))
            phase <= ST_TAIL;
      end else if (take_tail) begin
         phase <= ST_IDLE;
      end
   end

   // R4: a cycle without a valid word leaves the phase alone
   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(phase));
   // R3: the payload phase never runs with an exhausted count
   p_body_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
      (phase == ST_BODY) |-> (remain != '0));
endmodule

// File: rtl/frx_xor_acc.sv
module frx_xor_acc #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              add,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] sum
);
   always_ff @(posedge clk) begin
      if (rst || clr)
         sum <= '0;
      else if (add)
         sum <= sum ^ word;
   end

   // R5: the sum only moves when a payload word is folded in or cleared
   p_sum_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      (!add && !clr) |=> $stable(sum));
endmodule

// File: rtl/frx_verdict.sv
module frx_verdict #(
   parameter int DATA_W = 8,
   parameter int PKT_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take_tail,
   input  logic [DATA_W-1:0] tail_word,
   input  logic [DATA_W-1:0] sum,
   output logic [PKT_W-1:0]  slot,
   output logic              ok,
   output logic              err
);
   logic match;
   assign match = (tail_word == sum);

   always_ff @(posedge clk) begin
      if (rst) begin
         slot <= '0;
         ok   <= 1'b0;
         err  <= 1'b0;
      end else begin
         ok  <= take_tail && match;
         err <= take_tail && !match;
         if (take_tail && match)
            slot <= slot + 1'b1;
      end
   end

   p_excl_r6: assert property (@(posedge clk) disable iff (rst)
      !(ok && err));
   p_step_r5: assert property (@(posedge clk) disable iff (rst)
      ok |-> (slot == PKT_W'($past(slot) + 1'b1)));
   p_keep_r6: assert property (@(posedge clk) disable iff (rst)
      err |-> (slot == $past(slot)));
   p_single_r5: assert property (@(posedge clk) disable iff (rst)
      ok |=> !ok);
endmodule

// File: rtl/frx_wr_port.sv
module frx_wr_port #(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 4,
   parameter int PKT_W  = 4,
   parameter bit WR_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en_i,
   input  logic [PKT_W-1:0]  pkt_i,
   input  logic [LEN_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              en_o,
   output logic [PKT_W-1:0]  pkt_o,
   output logic [LEN_W-1:0]  idx_o,
   output logic [DATA_W-1:0] data_o
);
   generate
      if (WR_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) en_o <= 1'b0;
            else     en_o <= en_i;
            pkt_o  <= pkt_i;
            idx_o  <= idx_i;
            data_o <= data_i;
         end
      end else begin : g_comb
         assign en_o   = en_i;
         assign pkt_o  = pkt_i;
         assign idx_o  = idx_i;
         assign data_o = data_i;
      end
   endgenerate
endmodule

// File: rtl/frame_xor_rx.sv
module frame_xor_rx #(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 4,
   parameter int PKT_W  = 4,
   parameter bit WR_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              in_hdr,
   input  logic [DATA_W-1:0] in_word,
   output logic              wr_en,
   output logic [PKT_W-1:0]  wr_pkt,
   output logic [LEN_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic [PKT_W-1:0]  pkt_count,
   output logic              pkt_ok,
   output logic              pkt_err
);
   generate
      if (LEN_W < 1 || LEN_W > DATA_W) begin : g_bad_len
         $error("frame_xor_rx: LEN_W must be 1..DATA_W");
      end
      if (PKT_W < 1) begin : g_bad_pkt
         $error("frame_xor_rx: PKT_W must be at least 1");
      end
   endgenerate

   logic              take_hdr, take_body, take_tail;
   logic [LEN_W-1:0]  body_idx;
   logic [DATA_W-1:0] sum;

   frx_ctrl #(.LEN_W(LEN_W)) i_ctrl (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_hdr    (in_hdr),
      .hdr_len   (in_word[LEN_W-1:0]),
      .take_hdr  (take_hdr),
      .take_body (take_body),
      .take_tail (take_tail),
      .body_idx  (body_idx)
   );

   frx_xor_acc #(.DATA_W(DATA_W)) i_acc (
      .clk  (clk),
      .rst  (rst),
      .clr  (take_hdr),
      .add  (take_body),
      .word (in_word),
      .sum  (sum)
   );

   frx_verdict #(.DATA_W(DATA_W), .PKT_W(PKT_W)) i_verdict (
      .clk       (clk),
      .rst       (rst),
      .take_tail (take_tail),
      .tail_word (in_word),
      .sum       (sum),
      .slot      (pkt_count),
      .ok        (pkt_ok),
      .err       (pkt_err)
   );

   frx_wr_port #(.DATA_W(DATA_W), .LEN_W(LEN_W), .PKT_W(PKT_W),
                 .WR_REG(WR_REG)) i_wr (
      .clk    (clk),
      .rst    (rst),
      .en_i   (take_body),
      .pkt_i  (pkt_count),
      .idx_i  (body_idx),
      .data_i (in_word),
      .en_o   (wr_en),
      .pkt_o  (wr_pkt),
      .idx_o  (wr_idx),
      .data_o (wr_data)
   );

   // R3: word slot 0 is never written
   p_wr_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (wr_idx != '0));
   // R6: writes always target the slot not yet committed
   p_wr_slot_r6: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (wr_pkt == pkt_count));
   // R2: a write never coincides with a verdict pulse
   p_wr_no_verdict_r2: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> !(pkt_ok || pkt_err));
endmodule

// File: tb/test_frame_xor_rx.sv
module test_frame_xor_rx;
   localparam int DATA_W = 8;
   localparam int LEN_W  = 4;
   localparam int PKT_W  = 4;

   typedef struct {
      int    kind;   // 0 write, 1 accept, 2 reject
      int    pkt;    // write slot, or expected count after verdict
      int    idx;
      int    data;
      string tag;
   } ev_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic in_hdr = 1'b0;
   logic [DATA_W-1:0] in_word = '0;
   logic wr_en, pkt_ok, pkt_err;
   logic [PKT_W-1:0] wr_pkt, pkt_count;
   logic [LEN_W-1:0] wr_idx;
   logic [DATA_W-1:0] wr_data;

   int errors = 0;
   int checks = 0;
   int exp_pkt = 0;
   ev_t sb[$];

   always #10 clk = ~clk;

   frame_xor_rx #(.DATA_W(DATA_W), .LEN_W(LEN_W), .PKT_W(PKT_W)) i_frame_xor_rx (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_hdr(in_hdr), .in_word(in_word),
      .wr_en(wr_en), .wr_pkt(wr_pkt), .wr_idx(wr_idx), .wr_data(wr_data),
      .pkt_count(pkt_count), .pkt_ok(pkt_ok), .pkt_err(pkt_err)
   );

   function automatic void chk(bit good, string tag, string what, int act, int exp);
      checks++;
      if (!good) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endfunction

   task automatic drive(bit v, bit h, logic [DATA_W-1:0] w);
      @(posedge clk);
      #1;
      in_valid = v;
      in_hdr   = h;
      in_word  = w;
   endtask

   task automatic expect_ev(int kind, int pkt, int idx, int data, string tag);
      ev_t e;
      e.kind = kind; e.pkt = pkt; e.idx = idx; e.data = data; e.tag = tag;
      sb.push_back(e);
   endtask

   // Driver: header, payload (descending slots), check word; flags options.
   task automatic send_pkt(int len, int seed, bit corrupt, bit gaps, bit flag_body, string tag);
      logic [DATA_W-1:0] sum = '0;
      drive(1'b1, 1'b1, {4'hA, 4'(len)});
      for (int i = len; i >= 1; i--) begin
         logic [DATA_W-1:0] d = 8'(seed + i * 37);
         expect_ev(0, exp_pkt, i, int'(d), tag);
         drive(1'b1, flag_body && (i == len), d);
         if (gaps) drive(1'b0, 1'b1, 8'hFF);
         sum = sum ^ d;
      end
      if (corrupt) begin
         expect_ev(2, exp_pkt, 0, 0, tag);
         drive(1'b1, 1'b0, sum ^ 8'h5A);
      end else begin
         exp_pkt = (exp_pkt + 1) % (1 << PKT_W);
         expect_ev(1, exp_pkt, 0, 0, tag);
         drive(1'b1, 1'b0, sum);
      end
      drive(1'b0, 1'b0, 8'h00);
   endtask

   task automatic take_ev(int kind);
      ev_t e;
      if (sb.size() == 0) begin
         chk(1'b0, "R2 R4 R8", "unexpected output event", kind, -1);
      end else begin
         e = sb.pop_front();
         chk(e.kind == kind, e.tag, "event kind", kind, e.kind);
         if (kind == 0 && e.kind == 0) begin
            chk(int'(wr_pkt) == e.pkt, e.tag, "wr_pkt", int'(wr_pkt), e.pkt);
            chk(int'(wr_idx) == e.idx, e.tag, "wr_idx", int'(wr_idx), e.idx);
            chk(int'(wr_data) == e.data, e.tag, "wr_data", int'(wr_data), e.data);
         end else if (kind != 0) begin
            chk(int'(pkt_count) == e.pkt, e.tag, "pkt_count after verdict", int'(pkt_count), e.pkt);
         end
      end
   endtask

   // Monitor: away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         if (wr_en)   take_ev(0);
         if (pkt_ok)  take_ev(1);
         if (pkt_err) take_ev(2);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(pkt_count == '0, "R1", "pkt_count", int'(pkt_count), 0);
      chk(wr_en == 1'b0, "R1", "wr_en", int'(wr_en), 0);
      chk(pkt_ok == 1'b0 && pkt_err == 1'b0, "R1", "pulses", int'({pkt_ok, pkt_err}), 0);

      // R2 idle noise; R4 header flag without valid, then plain words
      drive(1'b1, 1'b0, 8'h00);
      drive(1'b1, 1'b0, 8'h13);
      drive(1'b0, 1'b1, 8'hA2);
      drive(1'b1, 1'b0, 8'h11);
      drive(1'b1, 1'b0, 8'h22);
      drive(1'b1, 1'b0, 8'h33);
      drive(1'b0, 1'b0, 8'h00);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(pkt_count == '0, "R2", "pkt_count after idle noise", int'(pkt_count), 0);
      chk(sb.size() == 0, "R4", "pending events", sb.size(), 0);

      send_pkt(3, 5, 1'b0, 1'b0, 1'b0, "R3 R5");
      send_pkt(2, 90, 1'b0, 1'b1, 1'b0, "R4");
      send_pkt(2, 17, 1'b1, 1'b0, 1'b0, "R6");
      send_pkt(1, 44, 1'b0, 1'b0, 1'b0, "R6 slot reuse");
      send_pkt(0, 0, 1'b0, 1'b0, 1'b0, "R7");
      send_pkt(0, 0, 1'b1, 1'b0, 1'b0, "R7 reject");
      send_pkt(4, 200, 1'b0, 1'b0, 1'b1, "R8 flag in body");
      drive(1'b1, 1'b0, 8'h03);
      drive(1'b0, 1'b0, 8'h00);
      send_pkt(15, 3, 1'b0, 1'b0, 1'b0, "R3 max length");
      for (int k = 0; k < 16; k++) send_pkt(1, k * 7, 1'b0, 1'b0, 1'b0, "R9");

      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(int'(pkt_count) == exp_pkt, "R9", "pkt_count after wrap", int'(pkt_count), exp_pkt);
      chk(sb.size() == 0, "R3", "events never produced", sb.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule